// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer

This block is the front end of a microprogrammed control unit. It holds a writable control store of 256 words of 32 bits, chooses the microaddress of the next word every cycle, and latches the fetched word into a microinstruction register. The downstream data path takes its microorders from that register. Choosing the next address and fetching the word form the first pipeline stage. Executing the word held in the register forms the second stage.

The next address comes from one of four sources, set by the sequencing field of the current word: step to the following address, jump unconditionally to the word's target field, jump to the target when a selected condition holds, or map the opcode held in the instruction register onto a fixed entry address. The condition flags (zero, negative, carry, overflow and a pending-interrupt bit) are captured into a state register at every clock edge. A conditional jump therefore tests the state produced while the previous word was executing, not the current one. Opcodes expand from 4 to 8, 12 or 16 bits. An all-ones leading nibble means the opcode continues into the next nibble, and each opcode length folds into its own address pattern. A write port loads the control store.

Top module: `useq_top`

## Requirements
- R1: A control-store write (csWe high at a clock edge) stores csData at csAddr at that edge. A fetch from the same address at the same edge returns the old word, and later fetches return the new word.
- R2: While rst is high at a clock edge, the microinstruction register becomes the all-zero NOP word, uAddr becomes 0x8B and the state register clears. The first word fetched after rst falls is the word at 0x8C.
- R3: Sequencing field uInstr[31:30] = 00 steps the next microaddress to uAddr+1, wrapping from 0xFF to 0x00.
- R4: Sequencing field 01 makes the next microaddress equal to the target field uInstr[25:18].
- R5: Sequencing field 10 jumps to uInstr[25:18] when (selected state bit XOR uInstr[26]) is 1, and otherwise steps to uAddr+1. The select field uInstr[29:27] picks 0 zero, 1 negative, 2 carry, 3 overflow or 4 interrupt-pending, mapped to stateIn bits 0 to 4. Select values 5 to 7 read as 0.
- R6: The state bit tested by a conditional word is the stateIn value present during the cycle before that word entered the microinstruction register.
- R7: Sequencing field 11 maps the instruction register. If ir[15:12]≠F the next address is {1,ir[15:12],000}. Otherwise, if ir[11:8]≠F, it is {0,ir[11:8],000}. Otherwise, if ir[7:4]≠F, it is {0,ir[7:4],100}. Otherwise it is {1,ir[3:0],100}.
- R8: At each edge without reset, uAddr takes the chosen microaddress and uInstr takes the control-store word at that address, so both outputs change together one cycle after the choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir | input | 16 | Instruction register contents for opcode mapping |
| stateIn | input | 5 | Flags from the data path: bit0 zero, bit1 negative, bit2 carry, bit3 overflow, bit4 interrupt pending |
| csWe | input | 1 | Control-store write enable |
| csAddr | input | 8 | Control-store write address |
| csData | input | 32 | Control-store write data |
| uAddr | output | 8 | Microaddress of the word in the microinstruction register |
| uInstr | output | 32 | Microinstruction register contents |

## Verification
The microinstruction register sits one edge downstream of the next-address choice. The bench therefore computes the expected address and word from the inputs it drives before an edge, and compares uAddr and uInstr shortly after that single edge. Condition tests lag by one more edge, so the bench model keeps its own copy of the flags captured at the previous edge and evaluates the branch from that copy. Writes take effect at their edge, but a same-edge fetch of the written address must still return the old word. The bench model therefore reads its shadow store before applying the write.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned UADDR_W = 8;
  localparam int unsigned UWORD_W = 32;
  localparam int unsigned IR_W = 16;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned NIB_N = IR_W / NIB_W;
  localparam int unsigned STATE_W = 5;
  localparam int unsigned CSEL_W = 3;
  localparam int unsigned SEQ_W = 2 + CSEL_W + 1 + UADDR_W;

  // sequencing field positions inside the microinstruction word
  localparam int unsigned TGT_LSB = UWORD_W - SEQ_W;
  localparam int unsigned INV_BIT = TGT_LSB + UADDR_W;
  localparam int unsigned CSEL_LSB = INV_BIT + 1;
  localparam int unsigned MODE_LSB = CSEL_LSB + CSEL_W;

  typedef enum logic [1:0] {
    SEQ_INC  = 2'b00,
    SEQ_JUMP = 2'b01,
    SEQ_COND = 2'b10,
    SEQ_MAP  = 2'b11
  } seqMode_e;

  typedef struct packed {
    seqMode_e             mode;
    logic [CSEL_W-1:0]    condSel;
    logic                 condInv;
    logic [UADDR_W-1:0]   target;
  } seqField_t;

  typedef struct packed {
    logic [UADDR_W-1:0] fetchAddr;
    logic               loadNop;
  } seqStrobe_t;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter logic [UADDR_W-1:0] RESET_ADDR = 8'h8C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IR_W-1:0]    ir,
  input  logic [STATE_W-1:0] stateIn,
  input  seqField_t          curSeq,
  output seqStrobe_t         strobe,
  output logic [UADDR_W-1:0] curAddr
);
  localparam logic [UADDR_W-1:0] PRE_RESET = RESET_ADDR - 1'b1;

  logic [STATE_W-1:0] stateReg;
  logic [UADDR_W-1:0] upcReg;
  logic [UADDR_W-1:0] incAddr;
  logic [UADDR_W-1:0] mapAddr;
  logic [UADDR_W-1:0] nextAddr;
  logic               condBit;
  logic [NIB_N-1:0]   nibAllOnes;
  logic [NIB_W-1:0]   nib [NIB_N];

  // nibble 0 is the leading opcode nibble ir[15:12]
  for (genvar gi = 0; gi < NIB_N; gi++) begin : g_nib
    assign nib[gi] = ir[IR_W-1-gi*NIB_W -: NIB_W];
    assign nibAllOnes[gi] = &nib[gi];
  end

  always_comb begin
    if (!nibAllOnes[0])      mapAddr = {1'b1, nib[0], 3'b000};
    else if (!nibAllOnes[1]) mapAddr = {1'b0, nib[1], 3'b000};
    else if (!nibAllOnes[2]) mapAddr = {1'b0, nib[2], 3'b100};
    else                     mapAddr = {1'b1, nib[3], 3'b100};
  end

  always_comb begin
    if (int'(curSeq.condSel) < STATE_W) condBit = stateReg[curSeq.condSel];
    else                                condBit = 1'b0;
  end

  assign incAddr = upcReg + 1'b1;

  always_comb begin
    unique case (curSeq.mode)
      SEQ_INC:  nextAddr = incAddr;
      SEQ_JUMP: nextAddr = curSeq.target;
      SEQ_COND: nextAddr = (condBit ^ curSeq.condInv) ? curSeq.target : incAddr;
      SEQ_MAP:  nextAddr = mapAddr;
      default:  nextAddr = incAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upcReg   <= PRE_RESET;
      stateReg <= '0;
    end else begin
      upcReg   <= nextAddr;
      stateReg <= stateIn;
    end
  end

  assign strobe.fetchAddr = nextAddr;
  assign strobe.loadNop   = rst;
  assign curAddr          = upcReg;
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic               clk,
  input  seqStrobe_t         strobe,
  input  logic               csWe,
  input  logic [UADDR_W-1:0] csAddr,
  input  logic [UWORD_W-1:0] csData,
  output logic [UWORD_W-1:0] mirWord
);
  localparam int unsigned DEPTH = 1 << UADDR_W;

  logic [UWORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (csWe) mem[csAddr] <= csData;
  end

  always_ff @(posedge clk) begin
    if (strobe.loadNop) mirWord <= '0;
    else                mirWord <= mem[strobe.fetchAddr];
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter logic [7:0] RESET_ADDR = 8'h8C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] ir,
  input  logic [4:0]  stateIn,
  input  logic        csWe,
  input  logic [7:0]  csAddr,
  input  logic [31:0] csData,
  output logic [7:0]  uAddr,
  output logic [31:0] uInstr
);
  seqStrobe_t strobe;
  seqField_t  curSeq;

  assign curSeq = seqField_t'(uInstr[UWORD_W-1:TGT_LSB]);

  useq_ctrl #(.RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ir      (ir),
    .stateIn (stateIn),
    .curSeq  (curSeq),
    .strobe  (strobe),
    .curAddr (uAddr)
  );

  useq_store u_store (
    .clk     (clk),
    .strobe  (strobe),
    .csWe    (csWe),
    .csAddr  (csAddr),
    .csData  (csData),
    .mirWord (uInstr)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] ir,
  input logic [7:0]  uAddr,
  input logic [13:0] seqWord
);
  logic [1:0] mode;
  logic [7:0] tgt;
  logic [7:0] pastAddrInc;
  assign mode = seqWord[13:12];
  assign tgt  = seqWord[7:0];

  always_ff @(posedge clk) pastAddrInc <= uAddr + 8'd1;

  p_reset_entry_r2: assert property (@(posedge clk)
    rst |=> (uAddr == 8'h8B && seqWord == 14'd0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (uAddr == pastAddrInc));

  p_jump_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (uAddr == $past(tgt)));

  p_cond_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (uAddr == $past(tgt) || uAddr == pastAddrInc));

  p_map_low_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (uAddr[1:0] == 2'b00));

  p_map_lead_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && ir[15:12] != 4'hF) |=>
      (uAddr == {1'b1, $past(ir[15:12]), 3'b000}));
endmodule

bind useq_top useq_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .ir      (ir),
  .uAddr   (uAddr),
  .seqWord (uInstr[31:18])
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] ir;
  logic [4:0]  stateIn;
  logic        csWe;
  logic [7:0]  csAddr;
  logic [31:0] csData;
  logic [7:0]  uAddr;
  logic [31:0] uInstr;

  int checks = 0;
  int fails  = 0;

  logic [31:0] shadow [256];
  logic [7:0]  mAddr;
  logic [31:0] mInstr;
  logic [4:0]  mState;

  always #5 clk = ~clk;

  useq_top dut (
    .clk(clk), .rst(rst), .ir(ir), .stateIn(stateIn),
    .csWe(csWe), .csAddr(csAddr), .csData(csData),
    .uAddr(uAddr), .uInstr(uInstr)
  );

  function automatic logic [7:0] mapOp(input logic [15:0] v);
    if (v[15:12] != 4'hF)     return {1'b1, v[15:12], 3'b000};
    else if (v[11:8] != 4'hF) return {1'b0, v[11:8], 3'b000};
    else if (v[7:4] != 4'hF)  return {1'b0, v[7:4], 3'b100};
    else                      return {1'b1, v[3:0], 3'b100};
  endfunction

  function automatic logic [7:0] predict(input logic [31:0] w, input logic [7:0] a,
                                         input logic [15:0] v, input logic [4:0] st);
    logic c;
    c = (w[29:27] <= 3'd4) ? st[w[29:27]] : 1'b0;
    case (w[31:30])
      2'b00:   return a + 8'd1;
      2'b01:   return w[25:18];
      2'b10:   return (c ^ w[26]) ? w[25:18] : a + 8'd1;
      default: return mapOp(v);
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; drives, steps one edge, checks
  task automatic cycle(input logic r, input logic [15:0] v, input logic [4:0] st,
                       input logic we, input logic [7:0] wa, input logic [31:0] wd,
                       input string tagOverride);
    logic [7:0]  eA;
    logic [31:0] eI;
    string tag;
    rst = r; ir = v; stateIn = st; csWe = we; csAddr = wa; csData = wd;
    if (r) begin
      eA = 8'h8B; eI = 32'd0; tag = "R2";
    end else begin
      eA = predict(mInstr, mAddr, v, mState);
      eI = shadow[eA];
      case (mInstr[31:30])
        2'b00: tag = "R3";
        2'b01: tag = "R4";
        2'b10: tag = "R5";
        default: tag = "R7";
      endcase
    end
    if (tagOverride != "") tag = tagOverride;
    if (we) shadow[wa] = wd;
    mState = r ? 5'd0 : st;
    mAddr = eA; mInstr = eI;
    @(posedge clk); #2;
    check({tag, " uAddr"}, {24'd0, uAddr}, {24'd0, eA});
    check({"R8 uInstr after ", tag}, uInstr, eI);
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] a, input logic [31:0] d);
    cycle(1'b1, 16'h0, 5'd0, 1'b1, a, d, "R1");
  endtask

  function automatic logic [31:0] mkWord(input logic [1:0] m, input logic [2:0] sel,
                                         input logic inv, input logic [7:0] t);
    return {m, sel, inv, t, 18'h2A5A5};
  endfunction

  initial begin
    #1ms;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] irs [5];
    logic [7:0]  exps [5];
    void'($urandom(32'h5EED1234));
    rst = 1'b1; ir = '0; stateIn = '0; csWe = 1'b0; csAddr = '0; csData = '0;
    mAddr = 8'h8B; mInstr = 32'd0; mState = 5'd0;
    @(negedge clk);
    // R1 preload: fill store through the write port during reset
    for (int i = 0; i < 256; i++) load(8'(i), $urandom);

    // R6: word at 0x8C jumps to 0x40 on zero flag; flag presented before it enters the register
    load(8'h8C, mkWord(2'b10, 3'd0, 1'b0, 8'h40));
    cycle(1'b0, 16'h0, 5'b00001, 1'b0, 8'h0, 32'h0, "R2 entry");
    cycle(1'b0, 16'h0, 5'b00000, 1'b0, 8'h0, 32'h0, "R6 taken");
    if (uAddr !== 8'h40) begin fails++; $display("FAIL R6 actual=%h expected=40", uAddr); end
    checks++;
    cycle(1'b1, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "");
    cycle(1'b0, 16'h0, 5'b00000, 1'b0, 8'h0, 32'h0, "R2 entry");
    cycle(1'b0, 16'h0, 5'b00001, 1'b0, 8'h0, 32'h0, "R6 not taken");
    if (uAddr !== 8'h8D) begin fails++; $display("FAIL R6 actual=%h expected=8d", uAddr); end
    checks++;

    // R7 directed opcode lengths with literal expected addresses
    irs  = '{16'h3ABC, 16'hF5AB, 16'hFF7A, 16'hFFF2, 16'hFFFF};
    exps = '{8'h98, 8'h28, 8'h3C, 8'h94, 8'hFC};
    load(8'h8C, mkWord(2'b11, 3'd0, 1'b0, 8'h00));
    for (int k = 0; k < 5; k++) begin
      cycle(1'b1, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "");
      cycle(1'b0, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "R2 entry");
      cycle(1'b0, irs[k], 5'd0, 1'b0, 8'h0, 32'h0, "R7");
      check("R7 literal map", {24'd0, uAddr}, {24'd0, exps[k]});
    end

    // R1 same-edge collision: step word at 0x8C, overwrite 0x8D at the fetch edge
    load(8'h8C, mkWord(2'b00, 3'd0, 1'b0, 8'h00));
    load(8'h8D, mkWord(2'b01, 3'd0, 1'b0, 8'h8D));
    cycle(1'b0, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "R2 entry");
    cycle(1'b0, 16'h0, 5'd0, 1'b1, 8'h8D, 32'hDEADBEEF, "R1 old word");
    cycle(1'b0, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "R1 new word");
    check("R1 new word", uInstr, 32'hDEADBEEF);

    // R3 wrap: step word at 0xFF
    load(8'h8C, mkWord(2'b01, 3'd0, 1'b0, 8'hFF));
    load(8'hFF, mkWord(2'b00, 3'd0, 1'b0, 8'h00));
    cycle(1'b0, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "R2 entry");
    cycle(1'b0, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "R4");
    cycle(1'b0, 16'h0, 5'd0, 1'b0, 8'h0, 32'h0, "R3 wrap");
    check("R3 wrap", {24'd0, uAddr}, 32'd0);

    // random run with occasional writes and resets
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] v;
      logic        r;
      logic        we;
      for (int q = 0; q < 4; q++)
        v[q*4 +: 4] = ($urandom_range(1, 0) == 1) ? 4'hF : 4'($urandom);
      r  = ($urandom_range(99, 0) == 0);
      we = ($urandom_range(9, 0) == 0);
      cycle(r, v, 5'($urandom), we, 8'($urandom), $urandom, "");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule